// File: doc/BRIEF.md
# PCM Bit-Clock Rate Detector

This block runs on the PCM bit clock and works out which of eleven supported bit-clock rates is present. It does this by counting bit-clock cycles between frame-sync pulses, which arrive at 8 kHz. It presents a 4-bit rate code that downstream clock logic can use. It also raises a found flag when the measured rate matches a supported one.

After detection is enabled, a run starts. The block first skips a number of frames so the clock can settle. It then adds up the cycle counts of the next group of frames. At the end of that group it compares the total with the expected total for every supported rate, and the first total within tolerance sets the code. The result is held until detection is switched off. When auto-detection is off, the block passes through a code supplied by the host and reports no detection.

Frame sync is sampled in the bit-clock domain, and a pulse is recognised by its rising edge. Switching the enable off and back on starts a fresh run. A fresh run repeats both the skip window and the counting window.

Top module: `pcm_rate_detect`

## Requirements
- R1: While reset is asserted, and in the first cycles after it is released, `rate_code` is 4'b0000 and `rate_found` is 0. While reset is asserted, `det_busy` is 0.
- R2: A run starts when `auto_en` is high. The first frame-sync rising edge starts frame 1. The lengths of frames 1 to 8 have no effect on the result.
- R3: The measured total is the number of bit-clock cycles from the 9th frame-sync rising edge to the 17th. The result is registered on the clock edge that samples the 17th rising edge.
- R4: Rate codes are assigned by expected cycles per frame, as follows. Code 0 is 32, code 1 is 64, code 2 is 96, code 3 is 128, code 4 is 192, code 5 is 193, code 6 is 256, code 7 is 386, code 8 is 512, code 9 is 772 and code 10 is 1024. These correspond to bit clocks from 256 kHz to 8.192 MHz with an 8 kHz frame sync.
- R5: A rate matches when the measured total is within ±2 cycles of 8 times its per-frame count. When the total is 3 or more cycles away from every expected total, nothing matches.
- R6: When no rate matches, `rate_found` stays 0 and the auto code is 4'b0000.
- R7: Once a run has finished, `det_busy` is 0. The code and flag then hold, and further frame-sync pulses do not change them.
- R8: While `auto_en` is 0, `rate_code` equals `host_code`, and both `rate_found` and `det_busy` are 0.
- R9: When `auto_en` goes from 0 to 1, a new run starts, and `det_busy` is 1 until the run ends. During the run `rate_found` is 0, even if the previous run matched.
- R10: The cycle total saturates at 16383 instead of wrapping. A window longer than that matches no rate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | PCM bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fsync | input | 1 | Frame sync, synchronous to clk |
| auto_en | input | 1 | 1 = auto-detect; a rise starts a run |
| host_code | input | 4 | Code used while auto_en is 0 |
| rate_code | output | 4 | Selected rate code |
| rate_found | output | 1 | Auto-detected rate matched |
| det_busy | output | 1 | A detection run is in progress |

## Verification
The bench builds the block with its default parameters: 8 skipped frames, 8 counted frames and a ±2-cycle tolerance. With 8 counted frames, the accumulator is 14 bits wide. That width puts the saturation limit within reach of a window of 2304-cycle frames. If the total wrapped instead, it would land on the 256-cycle rate and give a false match.

With the ±2 tolerance, offsets of ±2 and ±3 on one counted frame probe both sides of the match boundary. With 8 skipped frames, the bench can give the skip window very different frame lengths and confirm that they are ignored.

// File: rtl/pcd_pkg.sv
package pcd_pkg;
  localparam int NUM_RATES     = 11;
  localparam int CODE_W        = 4;
  localparam int MAX_PER_FRAME = 1024;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SEEK, ST_SKIP, ST_MEAS, ST_DONE
  } seq_state_t;

  // expected bit-clock cycles in one 8 kHz frame, indexed by code
  function automatic int unsigned cycles_per_frame(input int unsigned idx);
    case (idx)
      0:  return 32;
      1:  return 64;
      2:  return 96;
      3:  return 128;
      4:  return 192;
      5:  return 193;
      6:  return 256;
      7:  return 386;
      8:  return 512;
      9:  return 772;
      10: return 1024;
      default: return 0;
    endcase
  endfunction

  function automatic logic within_tol(input int unsigned total,
                                      input int unsigned target,
                                      input int unsigned tol);
    int unsigned diff;
    diff = (total >= target) ? (total - target) : (target - total);
    return diff <= tol;
  endfunction
endpackage

// File: rtl/pcd_fs_edge.sv
module pcd_fs_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic fsync,
  output logic edge_p
);
  logic fs_q;

  always_ff @(posedge clk) begin
    if (!rst_n) fs_q <= 1'b0;
    else        fs_q <= fsync;
  end

  assign edge_p = fsync & ~fs_q;

  // R2: an edge is never reported on two cycles in a row
  p_edge_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    edge_p |=> !edge_p);
endmodule

// File: rtl/pcd_frame_seq.sv
module pcd_frame_seq
  import pcd_pkg::*;
#(
  parameter int DISCARD_FRAMES = 8,
  parameter int AVG_FRAMES     = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       edge_p,
  output seq_state_t state,
  output logic       start_p,
  output logic       end_p
);
  localparam int MAXF   = (DISCARD_FRAMES > AVG_FRAMES) ? DISCARD_FRAMES : AVG_FRAMES;
  localparam int FCNT_W = $clog2(MAXF + 1);
  localparam logic [FCNT_W-1:0] SKIP_LAST = FCNT_W'(DISCARD_FRAMES);
  localparam logic [FCNT_W-1:0] MEAS_LAST = FCNT_W'(AVG_FRAMES - 1);
  localparam bit NO_SKIP = (DISCARD_FRAMES == 0);

  logic [FCNT_W-1:0] fcnt;

  assign start_p = edge_p && ((state == ST_SEEK && NO_SKIP) ||
                              (state == ST_SKIP && fcnt == SKIP_LAST));
  assign end_p   = edge_p && (state == ST_MEAS) && (fcnt == MEAS_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) begin
      state <= ST_IDLE;
      fcnt  <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          state <= ST_SEEK;
          fcnt  <= '0;
        end
        ST_SEEK: if (edge_p) begin
          if (NO_SKIP) begin
            state <= ST_MEAS;
            fcnt  <= '0;
          end else begin
            state <= ST_SKIP;
            fcnt  <= FCNT_W'(1);
          end
        end
        ST_SKIP: if (edge_p) begin
          if (fcnt == SKIP_LAST) begin
            state <= ST_MEAS;
            fcnt  <= '0;
          end else begin
            fcnt <= fcnt + 1'b1;
          end
        end
        ST_MEAS: if (edge_p) begin
          if (fcnt == MEAS_LAST) state <= ST_DONE;
          else                   fcnt  <= fcnt + 1'b1;
        end
        default: state <= state;
      endcase
    end
  end

  // R3: the window closes into the done state
  p_end_to_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    end_p && enable |=> state == ST_DONE);
  // R3: the window opens into measurement
  p_start_to_meas_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start_p && enable |=> state == ST_MEAS);
  // R7: done is left only through a disable
  p_done_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_DONE && enable |=> state == ST_DONE);
endmodule

// File: rtl/pcd_cycle_accum.sv
module pcd_cycle_accum #(
  parameter int ACC_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_p,
  input  logic             run,
  output logic [ACC_W-1:0] total
);
  localparam logic [ACC_W-1:0] ACC_MAX = '1;

  logic [ACC_W-1:0] acc;

  always_ff @(posedge clk) begin
    if (!rst_n)                      acc <= '0;
    else if (clear_p)                acc <= '0;
    else if (run && acc != ACC_MAX)  acc <= acc + 1'b1;
  end

  // the closing edge cycle itself belongs to the window
  assign total = (acc == ACC_MAX) ? ACC_MAX : acc + 1'b1;

  // R10: the accumulator never steps backwards while running
  p_no_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    run && !clear_p |=> acc >= $past(acc));
endmodule

// File: rtl/pcd_rate_match.sv
module pcd_rate_match
  import pcd_pkg::*;
#(
  parameter int ACC_W      = 14,
  parameter int AVG_FRAMES = 8,
  parameter int TOL_CYCLES = 2
) (
  input  logic [ACC_W-1:0]     total,
  output logic [NUM_RATES-1:0] hit_vec,
  output logic                 hit,
  output logic [CODE_W-1:0]    hit_idx
);
  for (genvar g = 0; g < NUM_RATES; g++) begin : g_win
    localparam int unsigned TARGET = AVG_FRAMES * cycles_per_frame(g);
    assign hit_vec[g] = within_tol(int'(total), TARGET, TOL_CYCLES);
  end

  always_comb begin
    hit_idx = '0;
    for (int k = NUM_RATES - 1; k >= 0; k--) begin
      if (hit_vec[k]) hit_idx = CODE_W'(k);
    end
  end

  assign hit = |hit_vec;
endmodule

// File: rtl/pcm_rate_detect.sv
module pcm_rate_detect
  import pcd_pkg::*;
#(
  parameter int DISCARD_FRAMES = 8,
  parameter int AVG_FRAMES     = 8,
  parameter int TOL_CYCLES     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fsync,
  input  logic              auto_en,
  input  logic [CODE_W-1:0] host_code,
  output logic [CODE_W-1:0] rate_code,
  output logic              rate_found,
  output logic              det_busy
);
  localparam int ACC_W = $clog2(AVG_FRAMES * MAX_PER_FRAME) + 1;

  logic                 edge_p, start_p, end_p, hit;
  seq_state_t           state;
  logic [ACC_W-1:0]     total;
  logic [NUM_RATES-1:0] hit_vec;
  logic [CODE_W-1:0]    hit_idx, det_code;
  logic                 found;

  pcd_fs_edge u_edge (
    .clk(clk), .rst_n(rst_n), .fsync(fsync), .edge_p(edge_p)
  );

  pcd_frame_seq #(
    .DISCARD_FRAMES(DISCARD_FRAMES), .AVG_FRAMES(AVG_FRAMES)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .enable(auto_en), .edge_p(edge_p),
    .state(state), .start_p(start_p), .end_p(end_p)
  );

  pcd_cycle_accum #(.ACC_W(ACC_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .clear_p(start_p),
    .run(state == ST_MEAS), .total(total)
  );

  pcd_rate_match #(
    .ACC_W(ACC_W), .AVG_FRAMES(AVG_FRAMES), .TOL_CYCLES(TOL_CYCLES)
  ) u_match (
    .total(total), .hit_vec(hit_vec), .hit(hit), .hit_idx(hit_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n || !auto_en || state == ST_IDLE) begin
      found    <= 1'b0;
      det_code <= '0;
    end else if (end_p) begin
      found    <= hit;
      det_code <= hit ? hit_idx : '0;
    end
  end

  assign rate_code  = auto_en ? det_code : host_code;
  assign rate_found = found;
  assign det_busy   = (state == ST_SEEK) || (state == ST_SKIP) || (state == ST_MEAS);

  // R7: a found flag only exists after a finished run
  p_found_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rate_found |-> state == ST_DONE);
  // R5: tolerance windows never overlap
  p_onehot_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));
  // R8: manual mode drops the flag
  p_manual_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_en |=> !rate_found);
  // R6: a miss leaves a zero code
  p_miss_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    end_p && !hit && auto_en |=> det_code == '0 && !rate_found);
  // R9: busy and found are exclusive
  p_busy_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    det_busy |-> !rate_found);
  // R4: a found code lies inside the rate table
  p_code_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rate_found |-> det_code < CODE_W'(NUM_RATES));
endmodule

// File: tb/sim_pcm_rate_detect.sv
`timescale 1ns/1ps
module sim_pcm_rate_detect;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fsync = 1'b0;
  logic       auto_en = 1'b1;
  logic [3:0] host_code = 4'd0;
  logic [3:0] rate_code;
  logic       rate_found;
  logic       det_busy;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  pcm_rate_detect u0 (
    .clk(clk), .rst_n(rst_n), .fsync(fsync), .auto_en(auto_en),
    .host_code(host_code), .rate_code(rate_code),
    .rate_found(rate_found), .det_busy(det_busy)
  );

  always #2.5 clk = ~clk;

  function automatic int rate_hz(input int k);
    case (k)
      0: return 256000;   1: return 512000;   2: return 768000;
      3: return 1024000;  4: return 1536000;  5: return 1544000;
      6: return 2048000;  7: return 3088000;  8: return 4096000;
      9: return 6176000;  default: return 8192000;
    endcase
  endfunction

  // expected outcome for an 8-frame total
  function automatic void expect_for(input int total, output bit f, output int code);
    f = 0; code = 0;
    for (int k = 0; k < 11; k++) begin
      int tgt = 8 * (rate_hz(k) / 8000);
      int d = total - tgt;
      if (!f && d <= 2 && d >= -2) begin f = 1; code = k; end
    end
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame(input int len);
    @(negedge clk) fsync = 1'b1;
    @(negedge clk) fsync = 1'b0;
    repeat (len - 2) @(negedge clk);
  endtask

  // restart, 8 skipped frames, 8 counted frames (last one offset), closing edge
  task automatic run(input int skip_len, input int skip_var, input int per_frame,
                     input int delta, output int total);
    auto_en = 1'b0;
    idle(3);
    auto_en = 1'b1;
    idle(2);
    for (int i = 0; i < 8; i++) begin
      frame(skip_len + ((i * 37) % (skip_var + 1)));
      if (i == 3) begin
        chk("R9 found low during run", rate_found, 0);
        chk("R9 busy during run", det_busy, 1);
      end
    end
    total = 0;
    for (int i = 0; i < 8; i++) begin
      int l = (i == 7) ? per_frame + delta : per_frame;
      frame(l);
      total += l;
    end
    frame(40);
    idle(2);
  endtask

  task automatic run_and_check(input string req, input int skip_len, input int skip_var,
                               input int per_frame, input int delta);
    int total, code;
    bit f;
    run(skip_len, skip_var, per_frame, delta, total);
    expect_for(total, f, code);
    chk({req, " found"}, rate_found, f);
    chk({req, " code"}, rate_code, code);
    chk({req, " busy after run"}, det_busy, 0);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5150));
    idle(3);
    // R1 reset state
    chk("R1 code in reset", rate_code, 0);
    chk("R1 found in reset", rate_found, 0);
    chk("R1 busy in reset", det_busy, 0);
    rst_n = 1'b1;
    idle(2);
    chk("R1 code after reset", rate_code, 0);
    chk("R1 found after reset", rate_found, 0);

    // R3 R4: every rate exactly
    for (int k = 0; k < 11; k++)
      run_and_check("R4 rate table", 32, 0, rate_hz(k) / 8000, 0);

    // R5 R6: tolerance boundary around 256 cycles per frame
    run_and_check("R5 plus two", 32, 0, 256, 2);
    run_and_check("R5 minus two", 32, 0, 256, -2);
    run_and_check("R6 plus three", 32, 0, 256, 3);
    chk("R6 miss code zero", rate_code, 0);
    run_and_check("R6 minus three", 32, 0, 256, -3);
    run_and_check("R6 between 192 and 193", 32, 0, 192, 4);

    // R2: wildly varying skipped frames have no effect
    run_and_check("R2 skip window ignored", 700, 300, 64, 0);
    chk("R2 code is 1", rate_code, 1);

    // R7: later frames do not change a finished result
    run_and_check("R7 base", 40, 10, 772, 1);
    for (int i = 0; i < 3; i++) frame(100);
    idle(2);
    chk("R7 code held", rate_code, 9);
    chk("R7 found held", rate_found, 1);
    chk("R7 busy low", det_busy, 0);

    // R8: manual code passthrough
    auto_en = 1'b0;
    host_code = 4'd9;
    idle(3);
    chk("R8 manual code", rate_code, 9);
    chk("R8 manual found", rate_found, 0);
    chk("R8 manual busy", det_busy, 0);
    host_code = 4'd15;
    frame(50);
    chk("R8 manual code 15", rate_code, 15);
    chk("R8 manual found after fsync", rate_found, 0);

    // R10: 8 frames of 2304 total 18432; a wrapped count would look like rate 6
    run_and_check("R10 saturation", 32, 0, 2304, 0);
    chk("R10 no false match", rate_found, 0);

    // random trials
    for (int t = 0; t < 6; t++) begin
      int k = $urandom_range(10, 0);
      int d = $urandom_range(6, 0) - 3;
      int s = $urandom_range(300, 20);
      run_and_check("R5 random", s, 50, rate_hz(k) / 8000, d);
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule